// File: doc/BRIEF.md
# Shader Program Store and Sequencer

This block keeps a small memory of 128-bit shader instructions and steps through them. The host loads a program through an upload port. An index command places the upload pointer, and each instruction write stores four 32-bit words at the pointer and then moves the pointer on by one. A start command names the entry index, so subroutines can sit below the main routine in the memory. The block then presents one instruction and its index on every cycle until the program ends.

Only the fields that control sequencing are decoded. Each instruction has a 5-bit scalar opcode made of one high bit and four low bits. It also has a target index, a condition-test enable and a last flag. The pass/fail result of the condition test comes in from outside, in the same cycle as the instruction it applies to. Jumps, subroutine calls and returns can all be conditional. Return addresses are held on a small stack.

Top module: `shader_prog_seq`

## Requirements
- R1: An accepted index command loads the upload pointer. An accepted instruction write stores `up_wr_data` at the pointer and then adds one to the pointer. After reset the pointer is 0.
- R2: An accepted start makes `busy` high from the next cycle, with `inst_idx` equal to `start_idx`. While `busy` is high, `inst_data` is the stored instruction at `inst_idx`. A non-control instruction advances `inst_idx` by one per cycle.
- R3: An instruction with bit 96 set (bit 0 of the fourth word) is the last one. `busy` falls after it, and `done` is high for exactly the first cycle in which `busy` is low.
- R4: The scalar opcode is {bit 0, bits 63:60}. Opcode 0x09 is a jump to the target index held in bits 66 and up (ADDR_W bits). With bit 14 clear, the jump is taken whatever `cond_pass` is.
- R5: When bit 14 is set, a jump, call or return is taken only if `cond_pass` is high in that cycle. Otherwise execution continues at the next index.
- R6: Opcode 0x0B is a call. It pushes the index plus one and goes to the target. Opcode 0x0C is a return, which resumes at the most recently pushed index.
- R7: A return taken with an empty stack ends the run, with the same `busy`/`done` behaviour as R3.
- R8: A call taken while the stack already holds STACK_DEPTH entries pushes nothing. It continues at the next index and sets `stack_ovf`, which stays set until the next accepted start clears it.
- R9: Index commands and instruction writes that arrive while `busy` is high are discarded. They change neither the memory nor the pointer.
- R10: A start that arrives while `busy` is high is ignored, and the sequence carries on unchanged.
- R11: After reset, `busy`, `done` and `stack_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_from_valid | input | 1 | Load the upload pointer |
| up_from_idx | input | ADDR_W | New upload pointer value |
| up_wr_valid | input | 1 | Store one instruction at the pointer |
| up_wr_data | input | 128 | Instruction to store |
| start_valid | input | 1 | Begin execution |
| start_idx | input | ADDR_W | Entry index |
| cond_pass | input | 1 | External condition result for the current instruction |
| busy | output | 1 | Execution in progress; `inst_idx`/`inst_data` are valid |
| inst_idx | output | ADDR_W | Index of the current instruction |
| inst_data | output | 128 | Current instruction |
| done | output | 1 | One-cycle pulse after the run ends |
| stack_ovf | output | 1 | Sticky return-stack overflow flag |

## Verification
On every cycle, the assertions check the following. A run can begin only on an accepted start, and it begins at the start index. `done` appears only in the cycle right after a run. The overflow flag rises only while a call meets a full stack. The stack is never pushed when full or popped when empty. The upload pointer stays frozen while the block is running.

The following can only be shown by the bench's scenarios, which compare the full index trace and instruction contents against a queue of expected steps:
- that each control flow goes to the right place: taken and failed conditional jumps, nested call/return, recursion up to overflow, and a return on an empty stack;
- that uploads and starts arriving during a run really are discarded.

// File: rtl/shader_prog_seq_pkg.sv
package shader_prog_seq_pkg;
   localparam int WORD_W  = 32;
   localparam int WORDS   = 4;
   localparam int INST_W  = WORD_W * WORDS;

   // field positions inside the 128-bit instruction
   localparam int OPH_BIT   = 0;               // opcode high bit, word 0
   localparam int COND_BIT  = 14;              // condition-test enable, word 0
   localparam int OPL_LSB   = WORD_W + 28;     // opcode low nibble, word 1
   localparam int TGT_LSB   = 2 * WORD_W + 2;  // jump target, word 2
   localparam int LAST_BIT  = 3 * WORD_W;      // end-of-program flag, word 3

   typedef logic [4:0] sop_t;
   localparam sop_t SOP_JMP  = 5'h09;
   localparam sop_t SOP_CALL = 5'h0B;
   localparam sop_t SOP_RET  = 5'h0C;

   function automatic sop_t get_sop(input logic [INST_W-1:0] ins);
      return {ins[OPH_BIT], ins[OPL_LSB +: 4]};
   endfunction
endpackage

// File: rtl/seq_inst_store.sv
module seq_inst_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
   parameter int DEPTH = 4,
   parameter int DW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] top,
   output logic          empty,
   output logic          full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (push) cnt_q <= cnt_q + 1'b1;
      else if (pop)  cnt_q <= cnt_q - 1'b1;
   end

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   generate
      if (DEPTH == 1) begin : g_single
         logic [DW-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (push) ent_q <= din;
         end
         assign top = ent_q;
      end else begin : g_array
         logic [DW-1:0] ent_q [DEPTH];
         always_ff @(posedge clk) begin
            if (push) ent_q[cnt_q] <= din;
         end
         assign top = ent_q[cnt_q - 1'b1];
      end
   endgenerate

   assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/shader_prog_seq.sv
module shader_prog_seq
   import shader_prog_seq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int STACK_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_from_valid,
   input  logic [ADDR_W-1:0] up_from_idx,
   input  logic              up_wr_valid,
   input  logic [127:0]      up_wr_data,
   input  logic              start_valid,
   input  logic [ADDR_W-1:0] start_idx,
   input  logic              cond_pass,
   output logic              busy,
   output logic [ADDR_W-1:0] inst_idx,
   output logic [127:0]      inst_data,
   output logic              done,
   output logic              stack_ovf
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("shader_prog_seq: ADDR_W must be 1..8");
      end
      if (STACK_DEPTH < 1) begin : g_bad_stack
         $error("shader_prog_seq: STACK_DEPTH must be at least 1");
      end
      if (TGT_LSB + ADDR_W > LAST_BIT) begin : g_bad_tgt
         $error("shader_prog_seq: target field overruns word 3");
      end
   endgenerate

   logic              run_q, done_q, ovf_q;
   logic [ADDR_W-1:0] pc_q, pc_d, up_ptr_q;
   logic [INST_W-1:0] ins;
   logic [ADDR_W-1:0] stk_top;
   logic              stk_empty, stk_full, stk_push, stk_pop;
   logic              start_acc, from_acc, wr_acc;
   logic              is_last, cond_ok, take_jmp, take_call, take_ret;
   logic              finish, ovf_set;
   logic [ADDR_W-1:0] tgt, wr_addr;
   sop_t              sop;

   // ---------------- upload path ----------------
   assign from_acc  = up_from_valid & ~run_q;
   assign wr_acc    = up_wr_valid   & ~run_q;
   assign start_acc = start_valid   & ~run_q;
   assign wr_addr   = from_acc ? up_from_idx : up_ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        up_ptr_q <= '0;
      else if (from_acc) up_ptr_q <= up_from_idx + ADDR_W'(wr_acc);
      else if (wr_acc)   up_ptr_q <= up_ptr_q + 1'b1;
   end

   seq_inst_store #(.ADDR_W(ADDR_W), .DATA_W(INST_W)) u_store (
      .clk     (clk),
      .wr_en   (wr_acc),
      .wr_addr (wr_addr),
      .wr_data (up_wr_data),
      .rd_addr (pc_q),
      .rd_data (ins)
   );

   // ---------------- sequencing decode ----------------
   assign sop       = get_sop(ins);
   assign tgt       = ins[TGT_LSB +: ADDR_W];
   assign is_last   = ins[LAST_BIT];
   assign cond_ok   = ~ins[COND_BIT] | cond_pass;
   assign take_jmp  = run_q & ~is_last & cond_ok & (sop == SOP_JMP);
   assign take_call = run_q & ~is_last & cond_ok & (sop == SOP_CALL);
   assign take_ret  = run_q & ~is_last & cond_ok & (sop == SOP_RET);

   assign stk_push = take_call & ~stk_full;
   assign ovf_set  = take_call &  stk_full;
   assign stk_pop  = take_ret  & ~stk_empty;
   assign finish   = run_q & (is_last | (take_ret & stk_empty));

   always_comb begin
      pc_d = pc_q + 1'b1;
      if (take_jmp || stk_push) pc_d = tgt;
      else if (stk_pop)         pc_d = stk_top;
   end

   seq_ret_stack #(.DEPTH(STACK_DEPTH), .DW(ADDR_W)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_acc),
      .push  (stk_push),
      .pop   (stk_pop),
      .din   (pc_q + 1'b1),
      .top   (stk_top),
      .empty (stk_empty),
      .full  (stk_full)
   );

   // ---------------- run state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pc_q   <= '0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (start_acc) begin
            run_q <= 1'b1;
            pc_q  <= start_idx;
            ovf_q <= 1'b0;
         end else if (run_q) begin
            if (finish) run_q <= 1'b0;
            else        pc_q  <= pc_d;
            if (ovf_set) ovf_q <= 1'b1;
         end
      end
   end

   assign busy      = run_q;
   assign inst_idx  = pc_q;
   assign inst_data = ins;
   assign done      = done_q;
   assign stack_ovf = ovf_q;

   // ---------------- assertions ----------------
   assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start_valid) && inst_idx == $past(start_idx)));
   assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_ovf_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stack_ovf) |-> ($past(busy) && $past(stk_full)));
   assert_ptr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(up_ptr_q));
endmodule

// File: tb/shader_prog_seq_tb.sv
`timescale 1ns/1ps
module shader_prog_seq_tb;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          up_from_valid = 1'b0;
   logic [AW-1:0] up_from_idx = '0;
   logic          up_wr_valid = 1'b0;
   logic [127:0]  up_wr_data = '0;
   logic          start_valid = 1'b0;
   logic [AW-1:0] start_idx = '0;
   logic          cond_pass = 1'b0;
   logic          busy, done, stack_ovf;
   logic [AW-1:0] inst_idx;
   logic [127:0]  inst_data;

   always #2.5 clk = ~clk;

   shader_prog_seq #(.ADDR_W(AW), .STACK_DEPTH(4)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .up_from_valid(up_from_valid), .up_from_idx(up_from_idx),
      .up_wr_valid(up_wr_valid), .up_wr_data(up_wr_data),
      .start_valid(start_valid), .start_idx(start_idx),
      .cond_pass(cond_pass), .busy(busy), .inst_idx(inst_idx),
      .inst_data(inst_data), .done(done), .stack_ovf(stack_ovf)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int done_cnt = 0;
   logic [127:0] bm [16];
   int bptr = 0;
   int exp_q[$];
   string req_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(input logic [4:0] op, input int tgt,
                                       input bit cen, input bit last, input int tag);
      logic [127:0] v;
      v = '0;
      v[0]       = op[4];
      v[14]      = cen;
      v[63:60]   = op[3:0];
      v[47:32]   = tag[15:0];
      v[66 +: 4] = tgt[3:0];
      v[96]      = last;
      return v;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected step idx", longint'(inst_idx), 0);
            end else begin
               int e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               check(inst_idx == e[AW-1:0], r, "step idx", longint'(inst_idx), longint'(e));
               check(inst_data == bm[e], r, "step data low word",
                     longint'(inst_data[63:0]), longint'(bm[e][63:0]));
            end
         end
         if (done) done_cnt++;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_from(input int idx);
      up_from_valid = 1'b1; up_from_idx = idx[AW-1:0];
      tick();
      up_from_valid = 1'b0;
      bptr = idx;
   endtask

   task automatic do_wr(input logic [127:0] d);
      up_wr_valid = 1'b1; up_wr_data = d;
      tick();
      up_wr_valid = 1'b0;
      bm[bptr] = d;
      bptr = (bptr + 1) % 16;
   endtask

   task automatic expect_step(input int idx, input string req);
      exp_q.push_back(idx);
      req_q.push_back(req);
   endtask

   // inject: 1 = stray start, 2 = stray upload commands
   task automatic run(input int s, input bit cp, input string req, input int inject);
      int d0;
      d0 = done_cnt;
      cond_pass = cp;
      start_valid = 1'b1; start_idx = s[AW-1:0];
      tick();
      start_valid = 1'b0;
      tick();
      if (inject == 1) begin
         start_valid = 1'b1; start_idx = 4'd12;
         tick();
         start_valid = 1'b0;
      end else if (inject == 2) begin
         up_from_valid = 1'b1; up_from_idx = 4'd0;
         tick();
         up_from_valid = 1'b0;
         up_wr_valid = 1'b1; up_wr_data = {128{1'b1}};
         tick();
         up_wr_valid = 1'b0;
      end
      while (busy) @(negedge clk);
      tick();
      check(done_cnt == d0 + 1, req, "done pulses", longint'(done_cnt - d0), 1);
      check(exp_q.size() == 0, req, "steps left", longint'(exp_q.size()), 0);
      check(!busy && !done, req, "idle after run", longint'({busy, done}), 0);
   endtask

   initial begin
      #(200000 * 5);
      check(1'b0, "WD", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) bm[i] = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !stack_ovf, "R11", "reset outputs",
            longint'({busy, done, stack_ovf}), 0);

      // R1: program written from reset pointer 0, no index command
      do_wr(mk(5'h00, 0, 0, 0, 16'h100));  // 0 subroutine body
      do_wr(mk(5'h0C, 0, 0, 0, 16'h101));  // 1 return
      do_wr(mk(5'h00, 0, 0, 0, 16'h102));  // 2 main entry
      do_wr(mk(5'h0B, 0, 0, 0, 16'h103));  // 3 call 0
      do_wr(mk(5'h09, 7, 0, 0, 16'h104));  // 4 jump 7
      do_wr(mk(5'h00, 0, 0, 0, 16'h105));  // 5 skipped
      do_wr(mk(5'h00, 0, 0, 0, 16'h106));  // 6 skipped
      do_wr(mk(5'h00, 0, 0, 1, 16'h107));  // 7 last
      // R1: second region via index command
      do_from(8);
      do_wr(mk(5'h09, 11, 1, 0, 16'h108)); // 8 conditional jump 11
      do_wr(mk(5'h00, 0, 0, 0, 16'h109));  // 9
      do_wr(mk(5'h00, 0, 0, 1, 16'h10A));  // 10 last
      do_wr(mk(5'h00, 0, 0, 1, 16'h10B));  // 11 last
      do_wr(mk(5'h0C, 0, 0, 0, 16'h10C));  // 12 return, empty stack
      do_wr(mk(5'h0B, 13, 0, 0, 16'h10D)); // 13 call self
      do_wr(mk(5'h0C, 0, 0, 0, 16'h10E));  // 14 return

      // R2 R4 R6 R10: entry at 2, call/return, unconditional jump, stray start
      expect_step(2, "R2"); expect_step(3, "R6"); expect_step(0, "R6");
      expect_step(1, "R6"); expect_step(4, "R6"); expect_step(7, "R4");
      run(2, 1'b0, "R10", 1);

      // R5: conditional jump taken, then not taken
      expect_step(8, "R5"); expect_step(11, "R5");
      run(8, 1'b1, "R5", 0);
      expect_step(8, "R5"); expect_step(9, "R5"); expect_step(10, "R3");
      run(8, 1'b0, "R5", 0);

      // R7: return with empty stack ends run
      expect_step(12, "R7");
      run(12, 1'b0, "R7", 0);
      check(!stack_ovf, "R8", "ovf clear before overflow", longint'(stack_ovf), 0);

      // R8 R9: recursion overflows a 4-deep stack, stray uploads during run
      for (int k = 0; k < 5; k++) expect_step(13, "R8");
      for (int k = 0; k < 5; k++) expect_step(14, "R8");
      run(13, 1'b0, "R9", 2);
      check(stack_ovf, "R8", "ovf flag set", longint'(stack_ovf), 1);

      // R9: pointer unchanged by refused commands (still 15)
      do_wr(mk(5'h00, 0, 0, 1, 16'h10F));
      expect_step(15, "R9");
      run(15, 1'b0, "R9", 0);
      check(!stack_ovf, "R8", "ovf cleared by new start", longint'(stack_ovf), 0);

      // R9: earlier contents intact after refused write
      expect_step(2, "R9"); expect_step(3, "R9"); expect_step(0, "R9");
      expect_step(1, "R9"); expect_step(4, "R9"); expect_step(7, "R9");
      run(2, 1'b1, "R9", 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule